// File: doc/BRIEF.md
# Startup Mode Selection Sequencer

After reset, a converter device has to settle on one of two ways of being configured. It can take its operating mode from four mode-select pins, which is stand-alone operation, or it can wait for software to program it over a register-write port, which is control-port operation. This sequencer makes that choice on the master clock. While reset is low it holds the device powered down with its control state at defaults. Once reset is released, a startup timer counts master-clock cycles. If software sets the control-enable flag before the timer runs out, the device stays in control-port operation and waits there until software clears its power-down flag. If the timer runs out first, the sequencer captures the mode pins on that same edge and starts the device in stand-alone operation.

The selected mode is held until the next reset. The mode pins double as control-bus wires, so traffic on the bus at the moment of timeout is captured as a stand-alone mode. Software that intends to use the control port must set the enable flag early. The timer width is a parameter: the default of 18 bits gives a timeout of 2^18 cycles, and a short width suits simulation.

Top module: `startup_mode_seq`

## Requirements
- R1: While `rst_n` is low, `op_mode` is 2'b00, `pwr_down` is 1, `running` is 0 and `pin_cfg` is 0.
- R2: If no enable write arrives, then on the 2^TMR_W-th rising clock edge after `rst_n` goes high, `op_mode` becomes 2'b01 (stand-alone) and `pin_cfg` takes the value `mode_pins` had at that edge.
- R3: A write to address 4'h8 with `wr_data` bit 7 set, on any edge up to and including the terminal edge, makes `op_mode` 2'b10 (control port) and loads `pwr_down` from `wr_data` bit 0. On the terminal edge the write wins over the timeout.
- R4: In control-port mode, each write to address 4'h8 loads `pwr_down` from `wr_data` bit 0. Writes to any other address change nothing.
- R5: `running` rises one cycle after stand-alone entry, or one cycle after `pwr_down` goes to 0 in control-port mode. It falls one cycle after `pwr_down` returns to 1.
- R6: Once selected, a mode holds until reset. An enable write in stand-alone mode is ignored, and `pin_cfg` does not follow later changes on `mode_pins`.
- R7: While the sequencer is still waiting, a write to address 4'h8 with bit 7 clear is ignored: `pwr_down` stays 1 and the timeout still occurs.
- R8: `pwr_down` is 1 and `running` is 0 while `op_mode` is 2'b00, and `pwr_down` is 0 in stand-alone mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| mode_pins | input | MODE_W | Mode-select pins, shared with the bus |
| op_mode | output | 2 | 00 waiting, 01 stand-alone, 10 control port |
| pwr_down | output | 1 | Power-down status |
| running | output | 1 | Device powered up and converting |
| pin_cfg | output | MODE_W | Mode pins captured at timeout |

## Verification
The enable write and the timer's terminal count can land on the same clock edge. The bench provokes this by sweeping the enable write across every edge from the first to one past the terminal edge. On the terminal edge, control-port mode with the written power-down value is expected. One edge later, the write must be ignored and stand-alone mode with the captured pins must remain. A separate sweep over all sixteen pin values checks that only the value present at the terminal edge is captured.

// File: rtl/startup_mode_seq.sv
module startup_mode_seq #(
  parameter int TMR_W    = 18,
  parameter int AW       = 4,
  parameter int DW       = 8,
  parameter int MODE_W   = 4,
  parameter int CTL_ADDR = 8,
  parameter int EN_BIT   = 7,
  parameter int PD_BIT   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [MODE_W-1:0] mode_pins,
  output logic [1:0]        op_mode,
  output logic              pwr_down,
  output logic              running,
  output logic [MODE_W-1:0] pin_cfg
);
  localparam logic [AW-1:0]    CTL_A = AW'(CTL_ADDR);
  localparam logic [TMR_W-1:0] T_END = {TMR_W{1'b1}};

  typedef enum logic [1:0] {M_WAIT = 2'b00, M_PINS = 2'b01, M_SOFT = 2'b10} mode_t;

  mode_t             st;
  logic [TMR_W-1:0]  cnt;
  logic              pd;
  logic              run;
  logic [MODE_W-1:0] cfg;

  wire ctl_wr = wr_en && (wr_addr == CTL_A);
  wire en_wr  = ctl_wr && wr_data[EN_BIT];
  wire expire = (cnt == T_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= M_WAIT;
      cnt <= '0;
      pd  <= 1'b1;
      run <= 1'b0;
      cfg <= '0;
    end else begin
      run <= (st != M_WAIT) && !pd;
      case (st)
        M_WAIT: begin
          if (en_wr) begin
            st <= M_SOFT;
            pd <= wr_data[PD_BIT];
          end else if (expire) begin
            st  <= M_PINS;
            cfg <= mode_pins;
            pd  <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        M_SOFT: if (ctl_wr) pd <= wr_data[PD_BIT];
        default: ;
      endcase
    end
  end

  assign op_mode  = st;
  assign pwr_down = pd;
  assign running  = run;
  assign pin_cfg  = cfg;
endmodule

// File: rtl/startup_mode_seq_chk.sv
module startup_mode_seq_chk #(
  parameter int MODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        op_mode,
  input logic              pwr_down,
  input logic              running,
  input logic [MODE_W-1:0] pin_cfg
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (op_mode == 2'b00 && pwr_down && !running));

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode != 2'b00) |=> (op_mode == $past(op_mode)));

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode == 2'b01) |=> $stable(pin_cfg));

  // R5
  run_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode != 2'b00 && !pwr_down) |=> running);

  // R5
  run_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !running);

  // R8
  wait_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode == 2'b00) |-> (pwr_down && !running));

  // R8
  pins_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode == 2'b01) |-> !pwr_down);
endmodule

bind startup_mode_seq startup_mode_seq_chk #(.MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_mode(op_mode),
  .pwr_down(pwr_down), .running(running), .pin_cfg(pin_cfg)
);

// File: tb/startup_mode_seq_bench.sv
module startup_mode_seq_bench;
  localparam int TW = 4;
  localparam int TEND = 1 << TW;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] wr_addr = 0, mode_pins = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] op_mode;
  logic pwr_down, running;
  logic [3:0] pin_cfg;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  startup_mode_seq #(.TMR_W(TW)) u_startup_mode_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode_pins(mode_pins), .op_mode(op_mode),
    .pwr_down(pwr_down), .running(running), .pin_cfg(pin_cfg));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    wr_en = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mode_pins = 4'hA;
    repeat (2) @(negedge clk);
    chk("R1 op_mode", op_mode, 0);
    chk("R1 pwr_down", pwr_down, 1);
    chk("R1 running", running, 0);
    chk("R1 pin_cfg", pin_cfg, 0);

    for (int p = 0; p < 16; p++) begin
      do_reset();
      mode_pins = 4'(p);
      repeat (TEND - 1) @(negedge clk);
      chk("R8 waiting op_mode", op_mode, 0);
      chk("R8 waiting pwr_down", pwr_down, 1);
      @(negedge clk);
      chk("R2 op_mode", op_mode, 1);
      chk("R2 pin_cfg", pin_cfg, p);
      chk("R5 running before", running, 0);
      mode_pins = ~4'(p);
      @(negedge clk);
      chk("R5 running after", running, 1);
      chk("R6 pin_cfg held", pin_cfg, p);
      chk("R8 stand-alone pwr_down", pwr_down, 0);
    end

    for (int j = 1; j <= TEND + 1; j++) begin
      for (int d = 0; d < 2; d++) begin
        do_reset();
        mode_pins = 4'h5;
        repeat (j - 1) @(negedge clk);
        wr(4'h8, 8'h80 | 8'(d));
        if (j <= TEND) begin
          chk("R3 op_mode", op_mode, 2);
          chk("R3 pwr_down", pwr_down, d);
          @(negedge clk);
          chk("R5 running", running, 1 - d);
          repeat (TEND + 4) @(negedge clk);
          chk("R6 control mode held", op_mode, 2);
        end else begin
          chk("R6 late enable op_mode", op_mode, 1);
          chk("R6 late enable pin_cfg", pin_cfg, 5);
          chk("R6 late enable pwr_down", pwr_down, 0);
          @(negedge clk);
          chk("R6 late enable running", running, 1);
        end
      end
    end

    do_reset();
    wr(4'h8, 8'h81);
    @(negedge clk);
    chk("R4 start pwr_down", pwr_down, 1);
    wr(4'h3, 8'h00);
    chk("R4 other addr pwr_down", pwr_down, 1);
    @(negedge clk);
    chk("R4 other addr running", running, 0);
    wr(4'h8, 8'h00);
    chk("R4 clear pwr_down", pwr_down, 0);
    chk("R5 running not yet", running, 0);
    @(negedge clk);
    chk("R5 running rise", running, 1);
    wr(4'h8, 8'h01);
    chk("R4 set pwr_down", pwr_down, 1);
    chk("R5 running still", running, 1);
    @(negedge clk);
    chk("R5 running fall", running, 0);
    chk("R6 mode kept", op_mode, 2);

    do_reset();
    mode_pins = 4'h9;
    repeat (2) @(negedge clk);
    wr(4'h8, 8'h00);
    chk("R7 pwr_down", pwr_down, 1);
    chk("R7 op_mode", op_mode, 0);
    repeat (TEND - 4) @(negedge clk);
    chk("R7 still waiting", op_mode, 0);
    @(negedge clk);
    chk("R7 timeout op_mode", op_mode, 1);
    chk("R7 timeout pin_cfg", pin_cfg, 9);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule